// File: doc/BRIEF.md
# PCM Serial Clock and Frame Sync Generator

This block produces the serial bit clock and the frame-sync pulse for a PCM audio port that always drives both of them. Everything runs on one system clock. The two possible source clocks reach the block as one-cycle tick enables. A select input picks which tick stream advances the dividers, and no second clock domain is involved. The bit clock toggles once every (clock divider + 1) selected ticks, so one bit lasts 2 × (divider + 1) ticks. A frame lasts (sync divider + 1) bits. Both divider fields are 9 bits wide, so the usual frame of 128 bits is programmed as 127.

The bit clock idles high. Each bit starts on its falling edge, the launch edge, and is sampled on its rising edge, the capture edge. The frame sync is high for exactly the first bit of every frame and changes on launch edges. The shift logic uses the two one-cycle strobes `launch_stb` and `capture_stb` instead of the clock itself.

An enable controls the clock. A continuous/gated option sets whether it keeps running while both transfer directions are idle. The clock only stops at a frame boundary. Divider values are taken at the start of each frame.

The controller is a three-state machine:
- IDLE: the clock is parked high.
- LOW: the first half of a bit, with the clock low.
- HIGH: the second half of a bit, with the clock high.

Its transitions are:
- START (IDLE→LOW): the block should run and a selected tick arrives. This opens a frame.
- CAPTURE (LOW→HIGH): the half-period count completes.
- NEXT_BIT (HIGH→LOW): the half completes and the frame is not finished.
- WRAP (HIGH→LOW): the half completes on the last bit and the block should still run. This opens a new frame.
- STOP (HIGH→IDLE): the half completes on the last bit and the block should no longer run.

Top module: `pcmclk_gen`

## Requirements
- R1: After reset `sclk` is 1, and `fsync`, `launch_stb` and `capture_stb` are 0. They stay that way while `sclk_en` is 0.
- R2: Consecutive clock edges (launch or capture) are exactly (`sclk_div`+1) selected ticks apart. With a tick every K system cycles, that is (`sclk_div`+1)·K cycles.
- R3: A frame contains exactly `sync_div`+1 launch edges. `sync_div`=0 gives a one-bit frame.
- R4: `fsync` rises together with the launch strobe of a frame's first bit and is high for exactly one bit period, 2·(`sclk_div`+1)·K cycles. In a one-bit frame it stays high.
- R5: `src_sel`=0 selects `tick_bus` as the divider source and `src_sel`=1 selects `tick_mux`. Every clock edge follows a tick of the selected source in the previous cycle.
- R6: When `sclk_en` is 0 the block finishes the current frame, then holds `sclk` high with no strobes, even in continuous mode.
- R7: With `cont_mode`=1 the clock keeps running while `tx_active` and `rx_active` are both 0. With `cont_mode`=0 and both inactive, it stops at the end of the frame.
- R8: A stop happens only after the last bit of a frame. When the block restarts, the first launch strobe comes with `fsync` high.
- R9: `sclk_div` and `sync_div` are sampled only when a frame starts. A change in the middle of a frame takes effect from the next frame.
- R10: `launch_stb` is high in exactly the cycle in which `sclk` has fallen, and `capture_stb` in exactly the cycle in which it has risen. `sclk` changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_sel | input | 1 | Source select: 0 bus tick, 1 audio mux tick |
| tick_bus | input | 1 | One-cycle enable per bus source clock period |
| tick_mux | input | 1 | One-cycle enable per audio mux source clock period |
| sclk_en | input | 1 | Serial clock enable |
| cont_mode | input | 1 | 1: run while idle; 0: stop at frame end when idle |
| tx_active | input | 1 | Transmit direction active |
| rx_active | input | 1 | Receive direction active |
| sclk_div | input | 9 | Half-period divider minus one |
| sync_div | input | 9 | Bits per frame minus one |
| sclk | output | 1 | Serial bit clock, idle high |
| fsync | output | 1 | Frame sync, high for the first bit |
| launch_stb | output | 1 | High in the cycle sclk has fallen |
| capture_stb | output | 1 | High in the cycle sclk has risen |

## Verification
All outputs are registered. An edge, its strobe and any change of `fsync` appear in the cycle after the posedge at which the qualifying selected tick is sampled. Every measurement is therefore taken between two strobes and counted in whole system cycles sampled on the falling clock edge, so the fixed one-cycle delay cancels out. After reprogramming, the bench lets two frame starts pass before it measures, because new divider values only apply from a frame boundary. Stop tests count the launch strobes that remain after activity is withdrawn at a known launch. They then watch a full bit period of silence.

// File: rtl/pcmclk_pkg.sv
package pcmclk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } pcmclk_state_t;
endpackage

// File: rtl/pcmclk_src_sel.sv
module pcmclk_src_sel #(
    parameter int SEL_W = 1,
    localparam int NUM_SRC = 1 << SEL_W
) (
    input  logic [NUM_SRC-1:0] ticks,
    input  logic [SEL_W-1:0]   sel,
    output logic               tick
);
    always_comb tick = ticks[sel];
endmodule

// File: rtl/pcmclk_half_cnt.sv
module pcmclk_half_cnt #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;

    always_comb done = tick && !clear && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (tick)
            cnt <= (cnt == limit) ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/pcmclk_gen.sv
module pcmclk_gen
    import pcmclk_pkg::*;
#(
    parameter int DIV_W = 9,
    parameter int FRM_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_sel,
    input  logic             tick_bus,
    input  logic             tick_mux,
    input  logic             sclk_en,
    input  logic             cont_mode,
    input  logic             tx_active,
    input  logic             rx_active,
    input  logic [DIV_W-1:0] sclk_div,
    input  logic [FRM_W-1:0] sync_div,
    output logic             sclk,
    output logic             fsync,
    output logic             launch_stb,
    output logic             capture_stb
);
    pcmclk_state_t state, nxt;

    logic             tick;
    logic             half_done;
    logic             run;
    logic             frame_end;
    logic             start_frame;
    logic [DIV_W-1:0] div_q;
    logic [FRM_W-1:0] frm_q;
    logic [FRM_W-1:0] bit_cnt;

    pcmclk_src_sel #(.SEL_W(1)) u_sel (
        .ticks ({tick_mux, tick_bus}),
        .sel   (src_sel),
        .tick  (tick)
    );

    pcmclk_half_cnt #(.W(DIV_W)) u_half (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state == ST_IDLE),
        .tick  (tick),
        .limit (div_q),
        .done  (half_done)
    );

    always_comb begin
        run       = sclk_en && (cont_mode || tx_active || rx_active);
        frame_end = (bit_cnt == frm_q);
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (run && tick) nxt = ST_LOW;
            ST_LOW:  if (half_done) nxt = ST_HIGH;
            ST_HIGH: if (half_done) nxt = (frame_end && !run) ? ST_IDLE : ST_LOW;
            default: nxt = ST_IDLE;
        endcase
        start_frame = ((state == ST_IDLE) && (nxt == ST_LOW)) ||
                      ((state == ST_HIGH) && (nxt == ST_LOW) && frame_end);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // output and frame registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk        <= 1'b1;
            fsync       <= 1'b0;
            launch_stb  <= 1'b0;
            capture_stb <= 1'b0;
            bit_cnt     <= '0;
            div_q       <= '0;
            frm_q       <= '0;
        end else begin
            sclk        <= (nxt != ST_LOW);
            launch_stb  <= (nxt == ST_LOW) && (state != ST_LOW);
            capture_stb <= (nxt == ST_HIGH) && (state == ST_LOW);
            if (start_frame) begin
                div_q   <= sclk_div;
                frm_q   <= sync_div;
                bit_cnt <= '0;
                fsync   <= 1'b1;
            end else if ((state == ST_HIGH) && (nxt == ST_LOW)) begin
                bit_cnt <= bit_cnt + 1'b1;
                fsync   <= 1'b0;
            end else if (nxt == ST_IDLE) begin
                fsync   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pcmclk_gen_chk.sv
module pcmclk_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic src_sel,
    input logic tick_bus,
    input logic tick_mux,
    input logic sclk,
    input logic fsync,
    input logic launch_stb,
    input logic capture_stb
);
    p_launch_falls_r10: assert property (@(posedge clk) disable iff (!rst_n)
        launch_stb |-> (!sclk && $past(sclk)));

    p_capture_rises_r10: assert property (@(posedge clk) disable iff (!rst_n)
        capture_stb |-> (sclk && !$past(sclk)));

    p_edge_has_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk) |-> (launch_stb || capture_stb));

    p_strobes_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({launch_stb, capture_stb}) <= 1);

    p_sync_on_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsync) |-> launch_stb);

    p_sync_drops_on_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fsync) && !sclk) |-> launch_stb);

    p_edge_after_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_stb || capture_stb) |-> $past(src_sel ? tick_mux : tick_bus));
endmodule

bind pcmclk_gen pcmclk_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_sel     (src_sel),
    .tick_bus    (tick_bus),
    .tick_mux    (tick_mux),
    .sclk        (sclk),
    .fsync       (fsync),
    .launch_stb  (launch_stb),
    .capture_stb (capture_stb)
);

// File: tb/sim_pcmclk_gen.sv
`timescale 1ns/1ps
module sim_pcmclk_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic src_sel = 1'b0;
    logic tick_bus = 1'b0;
    logic tick_mux = 1'b0;
    logic sclk_en = 1'b0;
    logic cont_mode = 1'b0;
    logic tx_active = 1'b0;
    logic rx_active = 1'b0;
    logic [8:0] sclk_div = '0;
    logic [8:0] sync_div = '0;
    logic sclk, fsync, launch_stb, capture_stb;

    int checks = 0;
    int failures = 0;
    int kb = 1;
    int km = 1;

    always #2 clk = ~clk;

    pcmclk_gen u0 (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
        .tick_bus(tick_bus), .tick_mux(tick_mux),
        .sclk_en(sclk_en), .cont_mode(cont_mode),
        .tx_active(tx_active), .rx_active(rx_active),
        .sclk_div(sclk_div), .sync_div(sync_div),
        .sclk(sclk), .fsync(fsync),
        .launch_stb(launch_stb), .capture_stb(capture_stb)
    );

    // tick generators, driven on the falling edge
    initial begin
        int cb = 0;
        int cm = 0;
        forever begin
            @(negedge clk);
            tick_bus = (cb == 0);
            tick_mux = (cm == 0);
            cb = (cb + 1 >= kb) ? 0 : cb + 1;
            cm = (cm + 1 >= km) ? 0 : cm + 1;
        end
    end

    function automatic int exp_half(int div, int k);
        return (div + 1) * k;
    endfunction

    function automatic int exp_bits(int s);
        return s + 1;
    endfunction

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_sync_launch;
        do @(negedge clk); while (!(launch_stb && fsync));
    endtask

    task automatic configure(int div, int s, int k, bit sel);
        sclk_div = 9'(div);
        sync_div = 9'(s);
        src_sel  = sel;
        if (sel) begin km = k; kb = k + 1; end
        else     begin kb = k; km = k + 2; end
        wait_sync_launch();
        wait_sync_launch();
    endtask

    // called at a frame-start launch; measures that whole frame
    task automatic measure_frame(int half, int bits, string tag);
        int cyc = 0;
        int last = 0;
        int bad = -1;
        int launches = 1;
        int fs_cyc = 1;
        bit pol_ok = 1'b1;
        forever begin
            @(negedge clk);
            cyc++;
            if (launch_stb || capture_stb) begin
                if ((cyc - last) != half && bad < 0) bad = cyc - last;
                last = cyc;
                if (launch_stb && sclk) pol_ok = 1'b0;
                if (capture_stb && !sclk) pol_ok = 1'b0;
            end
            if (launch_stb && fsync) break;
            if (launch_stb) launches++;
            if (fsync) fs_cyc++;
        end
        check(bad < 0, {tag, " R2 edge spacing"}, bad, half);
        check(launches == bits, {tag, " R3 bits per frame"}, launches, bits);
        check(fs_cyc == 2 * half, {tag, " R4 fsync width"}, fs_cyc, 2 * half);
        check(pol_ok, {tag, " R10 strobe polarity"}, int'(pol_ok), 1);
    endtask

    // count launches after activity is withdrawn at a frame start
    task automatic count_tail(int half, int s, output int launches, output int quiet_ok);
        int window = 2 * half * (s + 2) + 10;
        launches = 0;
        for (int i = 0; i < window; i++) begin
            @(negedge clk);
            if (launch_stb) launches++;
        end
        quiet_ok = 1;
        for (int i = 0; i < 2 * half + 10; i++) begin
            @(negedge clk);
            if (launch_stb || capture_stb || !sclk) quiet_ok = 0;
        end
    endtask

    initial begin
        #700000;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        int n, q, cnt;
        void'($urandom(32'd20240611));

        // R1: reset state, idle with clock disabled
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(sclk == 1'b1, "R1 sclk idle", int'(sclk), 1);
        check({fsync, launch_stb, capture_stb} == 3'b000, "R1 outputs low",
              int'({fsync, launch_stb, capture_stb}), 0);

        // R8: start with fsync on the first launch
        sclk_div = 9'd1; sync_div = 9'd3; kb = 1;
        sclk_en = 1'b1; tx_active = 1'b1;
        do @(negedge clk); while (!launch_stb);
        check(fsync == 1'b1, "R8 first launch has fsync", int'(fsync), 1);

        // directed corners
        configure(1, 3, 1, 1'b0);
        measure_frame(exp_half(1, 1), exp_bits(3), "dir basic");
        configure(0, 0, 1, 1'b0);
        measure_frame(exp_half(0, 1), exp_bits(0), "dir one-bit frame");
        configure(511, 1, 1, 1'b0);
        measure_frame(exp_half(511, 1), exp_bits(1), "dir max div");
        configure(0, 511, 1, 1'b0);
        measure_frame(exp_half(0, 1), exp_bits(511), "dir max frame");
        configure(2, 4, 3, 1'b1);
        measure_frame(exp_half(2, 3), exp_bits(4), "R5 mux source");
        configure(2, 4, 3, 1'b0);
        measure_frame(exp_half(2, 3), exp_bits(4), "R5 bus source");

        // constrained random
        for (int it = 0; it < 8; it++) begin
            int d = $urandom_range(0, 6);
            int s = $urandom_range(0, 9);
            int k = $urandom_range(1, 3);
            bit sl = 1'($urandom_range(0, 1));
            configure(d, s, k, sl);
            measure_frame(exp_half(d, k), exp_bits(s), sl ? "rnd R5 mux" : "rnd bus");
        end

        // R9: divider change mid-frame applies from next frame
        configure(1, 7, 1, 1'b0);
        wait_sync_launch();
        sclk_div = 9'd4;
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!capture_stb);
        check(cnt == exp_half(1, 1), "R9 old divider holds", cnt, exp_half(1, 1));
        wait_sync_launch();
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!capture_stb);
        check(cnt == exp_half(4, 1), "R9 new divider at frame", cnt, exp_half(4, 1));

        // R7: continuous mode runs with no activity
        configure(1, 3, 1, 1'b0);
        cont_mode = 1'b1; tx_active = 1'b0; rx_active = 1'b0;
        cnt = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (launch_stb) cnt++;
        end
        check(cnt >= 20, "R7 continuous keeps running", cnt, 25);

        // R6: enable off stops at frame end even in continuous mode
        wait_sync_launch();
        sclk_en = 1'b0;
        count_tail(exp_half(1, 1), 3, n, q);
        check(n == 3, "R6 remaining bits after disable", n, 3);
        check(q == 1, "R6 clock parked high", q, 1);

        // R7/R8: gated mode stops at the frame boundary
        sclk_en = 1'b1; cont_mode = 1'b0; rx_active = 1'b1;
        configure(2, 5, 2, 1'b1);
        wait_sync_launch();
        rx_active = 1'b0;
        count_tail(exp_half(2, 2), 5, n, q);
        check(n == 5, "R8 stop only after last bit", n, 5);
        check(q == 1, "R7 gated idle parks clock", q, 1);

        // R8: restart opens a new frame
        tx_active = 1'b1;
        do @(negedge clk); while (!launch_stb);
        check(fsync == 1'b1, "R8 restart launch has fsync", int'(fsync), 1);
        measure_frame(exp_half(2, 2), exp_bits(5), "R8 restart frame");

        report();
    end
endmodule